// File: doc/BRIEF.md
# Width-Limited In-Order Commit Controller

This block decides, once per clock, which of the oldest entries of a reorder buffer leave it. It is given a window of the `LOOK` oldest entries together with their status flags. It walks that window strictly from oldest to youngest and stops at the first entry that cannot go. It also stops once `WIDTH` instructions have committed in the cycle. Squashed entries are dropped on the way without using any of that width. The buffer storage, the rename map and the trap handler sit outside. The block tells them how many entries to pop this cycle, which entry must lose its ready mark, and which sequence number has to be replayed, executed non-speculatively or trapped on.

Entries that have not executed yet each stall in their own way. A serialising entry (non-speculative or barrier) waits for outstanding store writebacks to drain, then asks for non-speculative execution. An unexecuted load is sent back as an uncached replay. A faulting entry may only raise a trap when no stores are pending and it is the first candidate of the cycle. It then puts the thread into a trap-pending state, which freezes commit until the trap handler releases it. Statistics and buffer occupancy are reported one cycle after the cycle they describe.

Top module: `commit_ctl`

## Requirements
- R1: After reset, every registered output is zero, `trapPending` is 0, `freeCount` equals `DEPTH` and `robEmpty` is 1.
- R2: Window slot 0 is the oldest entry. Slots are visited in order. The walk stops at the first slot whose `headValid` or `headReady` is 0. When `selValid` is 0, nothing retires. `retireCount` gives, in the same cycle, the number of entries to pop.
- R3: At most `WIDTH` entries commit per cycle, and once `WIDTH` have committed no later slot is taken, not even a squashed one. A valid, ready entry with `headSquashed`=1 is popped without counting toward `WIDTH`. `cycleCommits` reports the commits of the previous cycle.
- R4: The cycle after one or more commits, `doneSeq` holds the sequence number and `savedPc` holds the next PC of the youngest entry committed. Both hold their values when nothing commits.
- R5: A head that is ready but not executed, with `headNonSpec` or `headBarrier` set, stops the walk. If `storesPending` is 0, then in the same cycle `clearReady`=1 and `clearSlot` gives its slot. In the next cycle `nonSpecReq` pulses with `reqSeq` holding its sequence number. If `storesPending` is 1, it only stops the walk.
- R6: A head that is ready but not executed, is not serialising and has `headLoad` set, stops the walk and is handled as uncached. `clearReady`/`clearSlot` mark it in the same cycle, and the next cycle `uncachedReq` pulses with its sequence number on `reqSeq`, whatever `storesPending` is. An unexecuted head of any other kind just stops the walk. At most one of `nonSpecReq`, `uncachedReq` and `trapReq` is high in a cycle.
- R7: An executed head with `headFault` set is never popped. If `storesPending` is 0 and nothing has committed earlier in the cycle, `trapReq` pulses the next cycle. Otherwise it waits.
- R8: A raised trap sets `trapPending` from the next cycle. While it is set, nothing retires. `trapResume` clears it the following cycle.
- R9: `committedTotal` adds the commits whose `headNop` flag is 0. `squashedTotal` adds the squashed entries popped.
- R10: `bwLimitTotal` adds one for every cycle whose commit count equals `WIDTH`.
- R11: Occupancy is updated by `insertCount` minus `retireCount`. `freeCount` and `robEmpty` show the result the next cycle. Entries inserted in a cycle are not candidates in that cycle, and `insertCount` has no effect on `retireCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| selValid | input | 1 | a thread is selected for commit this cycle |
| headValid | input | LOOK | window slot holds an entry |
| headReady | input | LOOK | entry is marked ready to commit |
| headSquashed | input | LOOK | entry was squashed |
| headExecuted | input | LOOK | entry has executed |
| headNonSpec | input | LOOK | entry must execute non-speculatively |
| headBarrier | input | LOOK | entry is a memory or write barrier |
| headLoad | input | LOOK | entry is a load |
| headFault | input | LOOK | entry carries a fault |
| headNop | input | LOOK | entry is a no-op or instruction prefetch |
| headSeq | input | LOOK*SEQ_W | sequence number per slot |
| headNextPc | input | LOOK*PC_W | next PC per slot |
| storesPending | input | 1 | stores still await writeback |
| insertCount | input | OCC_W | entries written into the buffer this cycle |
| trapResume | input | 1 | trap handler releases the thread |
| retireCount | output | CNT_W | entries to pop this cycle |
| clearReady | output | 1 | clear the ready mark of one entry |
| clearSlot | output | CNT_W | slot whose ready mark is cleared |
| doneSeq | output | SEQ_W | sequence number of the youngest commit |
| savedPc | output | PC_W | PC to resume from after the last commit |
| nonSpecReq | output | 1 | non-speculative execution request pulse |
| uncachedReq | output | 1 | uncached load replay request pulse |
| reqSeq | output | SEQ_W | sequence number for the request |
| trapReq | output | 1 | trap request pulse |
| trapPending | output | 1 | thread waits for trap handling |
| cycleCommits | output | CNT_W | commits in the previous cycle |
| committedTotal | output | STAT_W | committed instructions, no-ops excluded |
| squashedTotal | output | STAT_W | squashed entries popped |
| bwLimitTotal | output | STAT_W | cycles that used the full width |
| freeCount | output | OCC_W | free buffer entries |
| robEmpty | output | 1 | buffer holds no entries |

## Verification
Commits and a stall request can land in the same cycle. The one pairing that needs care is a commit in slot 0 followed by a serialising, load or faulting entry in slot 1. In that cycle `retireCount`, `doneSeq` and the request pulse must all reflect one walk. The fault must wait, because it is not the first candidate, while the serialising and load requests still go out. Directed cycles set up each such pair, with and without pending stores. Long random runs then mix squashed entries, width saturation and trap entry and release. A behavioural reference in the bench predicts every output each clock.

// File: rtl/commit_ctl_pkg.sv
package commit_ctl_pkg;
  parameter int CNT_W = 4;

  typedef enum logic [2:0] {
    SK_WAIT, SK_SQUASH, SK_COMMIT, SK_NONSPEC, SK_LOAD, SK_STUCK, SK_FAULT
  } slotKind_e;

  typedef enum logic {ST_RUN, ST_TRAP} thrState_e;

  typedef struct packed {
    logic [CNT_W-1:0] retireCnt;
    logic [CNT_W-1:0] commitCnt;
    logic [CNT_W-1:0] countedCnt;
    logic [CNT_W-1:0] squashCnt;
    logic             commitAny;
    logic [CNT_W-1:0] lastIdx;
    logic             nonSpecFire;
    logic             uncachedFire;
    logic             trapFire;
    logic [CNT_W-1:0] reqIdx;
    logic             bwLimit;
  } commitStrb_t;
endpackage

// File: rtl/commit_ctl_sched.sv
module commit_ctl_sched
  import commit_ctl_pkg::*;
#(
  parameter int WIDTH = 2,
  parameter int LOOK  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            selValid,
  input  logic [LOOK-1:0] headValid,
  input  logic [LOOK-1:0] headReady,
  input  logic [LOOK-1:0] headSquashed,
  input  logic [LOOK-1:0] headExecuted,
  input  logic [LOOK-1:0] headNonSpec,
  input  logic [LOOK-1:0] headBarrier,
  input  logic [LOOK-1:0] headLoad,
  input  logic [LOOK-1:0] headFault,
  input  logic [LOOK-1:0] headNop,
  input  logic            storesPending,
  input  logic            trapResume,
  output commitStrb_t     strb,
  output logic            trapPending
);
  slotKind_e kind [LOOK];
  thrState_e thrState;

  // Classify each window slot on its own flags; the walk below adds order.
  for (genvar s = 0; s < LOOK; s++) begin : g_kind
    assign kind[s] = (!headValid[s] || !headReady[s]) ? SK_WAIT :
                     headSquashed[s] ? SK_SQUASH :
                     !headExecuted[s] ? ((headNonSpec[s] || headBarrier[s]) ? SK_NONSPEC :
                                         headLoad[s] ? SK_LOAD : SK_STUCK) :
                     headFault[s] ? SK_FAULT : SK_COMMIT;
  end

  logic go;
  always_comb begin
    strb = '0;
    go = selValid && (thrState == ST_RUN);
    for (int i = 0; i < LOOK; i++) begin
      if (go && strb.commitCnt == CNT_W'(WIDTH)) go = 1'b0;
      if (go) begin
        case (kind[i])
          SK_SQUASH: begin
            strb.retireCnt = strb.retireCnt + 1'b1;
            strb.squashCnt = strb.squashCnt + 1'b1;
          end
          SK_COMMIT: begin
            strb.retireCnt = strb.retireCnt + 1'b1;
            strb.commitCnt = strb.commitCnt + 1'b1;
            if (!headNop[i]) strb.countedCnt = strb.countedCnt + 1'b1;
            strb.commitAny = 1'b1;
            strb.lastIdx   = CNT_W'(i);
          end
          SK_NONSPEC: begin
            if (!storesPending) begin
              strb.nonSpecFire = 1'b1;
              strb.reqIdx      = CNT_W'(i);
            end
            go = 1'b0;
          end
          SK_LOAD: begin
            strb.uncachedFire = 1'b1;
            strb.reqIdx       = CNT_W'(i);
            go = 1'b0;
          end
          SK_FAULT: begin
            if (!storesPending && strb.commitCnt == '0) strb.trapFire = 1'b1;
            go = 1'b0;
          end
          default: go = 1'b0;
        endcase
      end
    end
    strb.bwLimit = (strb.commitCnt == CNT_W'(WIDTH));
  end

  always_ff @(posedge clk) begin
    if (!rstN)              thrState <= ST_RUN;
    else if (strb.trapFire) thrState <= ST_TRAP;
    else if (trapResume)    thrState <= ST_RUN;
  end

  assign trapPending = (thrState == ST_TRAP);

  assert_stores_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    storesPending |-> !strb.nonSpecFire && !strb.trapFire);
  assert_fault_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.trapFire |-> strb.commitCnt == '0);
  assert_trap_enter_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.trapFire |=> trapPending);
  assert_trap_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    trapPending |-> strb.retireCnt == '0);
endmodule

// File: rtl/commit_ctl_path.sv
module commit_ctl_path
  import commit_ctl_pkg::*;
#(
  parameter int LOOK   = 4,
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int PC_W   = 32,
  parameter int STAT_W = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  commitStrb_t           strb,
  input  logic [LOOK*SEQ_W-1:0] headSeq,
  input  logic [LOOK*PC_W-1:0]  headNextPc,
  input  logic [OCC_W-1:0]      insertCount,
  output logic [SEQ_W-1:0]      doneSeq,
  output logic [PC_W-1:0]       savedPc,
  output logic                  nonSpecReq,
  output logic                  uncachedReq,
  output logic [SEQ_W-1:0]      reqSeq,
  output logic                  trapReq,
  output logic [CNT_W-1:0]      cycleCommits,
  output logic [STAT_W-1:0]     committedTotal,
  output logic [STAT_W-1:0]     squashedTotal,
  output logic [STAT_W-1:0]     bwLimitTotal,
  output logic [OCC_W-1:0]      freeCount,
  output logic                  robEmpty
);
  logic [OCC_W-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneSeq        <= '0;
      savedPc        <= '0;
      nonSpecReq     <= 1'b0;
      uncachedReq    <= 1'b0;
      reqSeq         <= '0;
      trapReq        <= 1'b0;
      cycleCommits   <= '0;
      committedTotal <= '0;
      squashedTotal  <= '0;
      bwLimitTotal   <= '0;
      occ            <= '0;
    end else begin
      if (strb.commitAny) begin
        doneSeq <= headSeq[strb.lastIdx*SEQ_W +: SEQ_W];
        savedPc <= headNextPc[strb.lastIdx*PC_W +: PC_W];
      end
      if (strb.nonSpecFire || strb.uncachedFire)
        reqSeq <= headSeq[strb.reqIdx*SEQ_W +: SEQ_W];
      nonSpecReq     <= strb.nonSpecFire;
      uncachedReq    <= strb.uncachedFire;
      trapReq        <= strb.trapFire;
      cycleCommits   <= strb.commitCnt;
      committedTotal <= committedTotal + STAT_W'(strb.countedCnt);
      squashedTotal  <= squashedTotal + STAT_W'(strb.squashCnt);
      bwLimitTotal   <= bwLimitTotal + STAT_W'(strb.bwLimit);
      occ            <= occ + insertCount - OCC_W'(strb.retireCnt);
    end
  end

  assign freeCount = OCC_W'(DEPTH) - occ;
  assign robEmpty  = (occ == '0);

  assert_one_request_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nonSpecReq, uncachedReq, trapReq}));
endmodule

// File: rtl/commit_ctl.sv
module commit_ctl
  import commit_ctl_pkg::*;
#(
  parameter int WIDTH  = 2,
  parameter int LOOK   = 4,
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int PC_W   = 32,
  parameter int STAT_W = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  selValid,
  input  logic [LOOK-1:0]       headValid,
  input  logic [LOOK-1:0]       headReady,
  input  logic [LOOK-1:0]       headSquashed,
  input  logic [LOOK-1:0]       headExecuted,
  input  logic [LOOK-1:0]       headNonSpec,
  input  logic [LOOK-1:0]       headBarrier,
  input  logic [LOOK-1:0]       headLoad,
  input  logic [LOOK-1:0]       headFault,
  input  logic [LOOK-1:0]       headNop,
  input  logic [LOOK*SEQ_W-1:0] headSeq,
  input  logic [LOOK*PC_W-1:0]  headNextPc,
  input  logic                  storesPending,
  input  logic [OCC_W-1:0]      insertCount,
  input  logic                  trapResume,
  output logic [CNT_W-1:0]      retireCount,
  output logic                  clearReady,
  output logic [CNT_W-1:0]      clearSlot,
  output logic [SEQ_W-1:0]      doneSeq,
  output logic [PC_W-1:0]       savedPc,
  output logic                  nonSpecReq,
  output logic                  uncachedReq,
  output logic [SEQ_W-1:0]      reqSeq,
  output logic                  trapReq,
  output logic                  trapPending,
  output logic [CNT_W-1:0]      cycleCommits,
  output logic [STAT_W-1:0]     committedTotal,
  output logic [STAT_W-1:0]     squashedTotal,
  output logic [STAT_W-1:0]     bwLimitTotal,
  output logic [OCC_W-1:0]      freeCount,
  output logic                  robEmpty
);
  commitStrb_t strb;

  commit_ctl_sched #(.WIDTH(WIDTH), .LOOK(LOOK)) u_sched (
    .clk, .rstN, .selValid, .headValid, .headReady, .headSquashed,
    .headExecuted, .headNonSpec, .headBarrier, .headLoad, .headFault,
    .headNop, .storesPending, .trapResume, .strb, .trapPending
  );

  commit_ctl_path #(.LOOK(LOOK), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W),
                    .STAT_W(STAT_W)) u_path (
    .clk, .rstN, .strb, .headSeq, .headNextPc, .insertCount, .doneSeq,
    .savedPc, .nonSpecReq, .uncachedReq, .reqSeq, .trapReq, .cycleCommits,
    .committedTotal, .squashedTotal, .bwLimitTotal, .freeCount, .robEmpty
  );

  assign retireCount = strb.retireCnt;
  assign clearReady  = strb.nonSpecFire || strb.uncachedFire;
  assign clearSlot   = strb.reqIdx;
endmodule

// File: tb/commit_ctl_test.sv
module commit_ctl_test;
  localparam int WIDTH = 2, LOOK = 4, DEPTH = 16, SEQ_W = 16, PC_W = 32, STAT_W = 16;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int CNT_W = commit_ctl_pkg::CNT_W;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rstN = 1'b0;
  logic selValid = 1'b0, storesPending = 1'b0, trapResume = 1'b0;
  logic [LOOK-1:0] hv = '0, hr = '0, hsq = '0, hex = '0, hns = '0, hbar = '0, hld = '0, hflt = '0, hnop = '0;
  logic [LOOK*SEQ_W-1:0] hSeq = '0;
  logic [LOOK*PC_W-1:0]  hPc = '0;
  logic [OCC_W-1:0] insertCount = '0;
  logic [CNT_W-1:0] retireCount, clearSlot, cycleCommits;
  logic clearReady, nonSpecReq, uncachedReq, trapReq, trapPending, robEmpty;
  logic [SEQ_W-1:0] doneSeq, reqSeq;
  logic [PC_W-1:0] savedPc;
  logic [STAT_W-1:0] committedTotal, squashedTotal, bwLimitTotal;
  logic [OCC_W-1:0] freeCount;

  commit_ctl #(.WIDTH(WIDTH), .LOOK(LOOK), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W),
               .STAT_W(STAT_W)) uut (
    .clk, .rstN, .selValid, .headValid(hv), .headReady(hr), .headSquashed(hsq),
    .headExecuted(hex), .headNonSpec(hns), .headBarrier(hbar), .headLoad(hld),
    .headFault(hflt), .headNop(hnop), .headSeq(hSeq), .headNextPc(hPc),
    .storesPending, .insertCount, .trapResume, .retireCount, .clearReady, .clearSlot,
    .doneSeq, .savedPc, .nonSpecReq, .uncachedReq, .reqSeq, .trapReq, .trapPending,
    .cycleCommits, .committedTotal, .squashedTotal, .bwLimitTotal, .freeCount, .robEmpty
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0, seqBase = 16;
  bit done = 0;

  // Reference state
  longint mDone, mPc, mReqSeq, mTot, mSq, mBw;
  int mOcc, mCyc;
  bit mNs, mUc, mTrapReq, mTrapPend;
  // Per-cycle prediction
  int eRet, eSlot, eCmt, eCounted, eSqn, eLast;
  bit eNs, eUc, eTrap;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic predict();
    int i;
    eRet = 0; eCmt = 0; eCounted = 0; eSqn = 0; eLast = 0; eSlot = 0;
    eNs = 0; eUc = 0; eTrap = 0;
    if (!selValid || mTrapPend) return;
    for (i = 0; i < LOOK; i++) begin
      if (eCmt == WIDTH) break;
      if (!hv[i] || !hr[i]) break;
      if (hsq[i]) begin eRet++; eSqn++; continue; end
      if (!hex[i]) begin
        if (hns[i] || hbar[i]) begin
          if (!storesPending) begin eNs = 1; eSlot = i; end
        end else if (hld[i]) begin
          eUc = 1; eSlot = i;
        end
        break;
      end
      if (hflt[i]) begin
        if (!storesPending && eCmt == 0) eTrap = 1;
        break;
      end
      eCmt++; eRet++; eLast = i;
      if (!hnop[i]) eCounted++;
    end
  endtask

  task automatic checkRegs(string tag);
    chk({tag, " R4 doneSeq"}, doneSeq, mDone);
    chk({tag, " R4 savedPc"}, savedPc, mPc);
    chk({tag, " R5 nonSpecReq"}, nonSpecReq, mNs);
    chk({tag, " R6 uncachedReq"}, uncachedReq, mUc);
    if (mNs || mUc) chk({tag, " R5 reqSeq"}, reqSeq, mReqSeq);
    chk({tag, " R7 trapReq"}, trapReq, mTrapReq);
    chk({tag, " R8 trapPending"}, trapPending, mTrapPend);
    chk({tag, " R3 cycleCommits"}, cycleCommits, mCyc);
    chk({tag, " R9 committedTotal"}, committedTotal, mTot);
    chk({tag, " R9 squashedTotal"}, squashedTotal, mSq);
    chk({tag, " R10 bwLimitTotal"}, bwLimitTotal, mBw);
    chk({tag, " R11 freeCount"}, freeCount, DEPTH - mOcc);
    chk({tag, " R11 robEmpty"}, robEmpty, mOcc == 0);
  endtask

  task automatic step(string tag);
    #1;
    predict();
    chk({tag, " R2 retireCount"}, retireCount, eRet);
    chk({tag, " R5 clearReady"}, clearReady, eNs || eUc);
    if (eNs || eUc) chk({tag, " R6 clearSlot"}, clearSlot, eSlot);
    @(posedge clk); #1;
    if (eCmt > 0) begin
      mDone = hSeq[eLast*SEQ_W +: SEQ_W];
      mPc = hPc[eLast*PC_W +: PC_W];
    end
    if (eNs || eUc) mReqSeq = hSeq[eSlot*SEQ_W +: SEQ_W];
    mNs = eNs; mUc = eUc; mTrapReq = eTrap;
    if (eTrap) mTrapPend = 1; else if (trapResume) mTrapPend = 0;
    mCyc = eCmt;
    mTot = (mTot + eCounted) % 65536;
    mSq = (mSq + eSqn) % 65536;
    if (eCmt == WIDTH) mBw = (mBw + 1) % 65536;
    mOcc = mOcc + int'(insertCount) - eRet;
    checkRegs(tag);
  endtask

  // Empty window, fresh sequence numbers, refill when room.
  task automatic clr();
    hv = '0; hr = '0; hsq = '0; hex = '0; hns = '0; hbar = '0; hld = '0; hflt = '0; hnop = '0;
    selValid = 1; storesPending = 0; trapResume = 0;
    insertCount = OCC_W'((mOcc <= DEPTH - LOOK) ? LOOK : 0);
    for (int i = 0; i < LOOK; i++) begin
      hSeq[i*SEQ_W +: SEQ_W] = SEQ_W'(seqBase + i);
      hPc[i*PC_W +: PC_W] = $urandom;
    end
    seqBase += 16;
  endtask

  // Ready entry in slot i; kinds: 0 commit, 1 squash, 2 nonspec, 3 barrier, 4 load, 5 fault, 6 nop
  task automatic put(int i, int k);
    hv[i] = 1; hr[i] = 1; hex[i] = 1;
    case (k)
      1: hsq[i] = 1;
      2: begin hex[i] = 0; hns[i] = 1; end
      3: begin hex[i] = 0; hbar[i] = 1; end
      4: begin hex[i] = 0; hld[i] = 1; end
      5: hflt[i] = 1;
      6: hnop[i] = 1;
      default: ;
    endcase
  endtask

  initial begin
    mDone = 0; mPc = 0; mReqSeq = 0; mTot = 0; mSq = 0; mBw = 0;
    mOcc = 0; mCyc = 0; mNs = 0; mUc = 0; mTrapReq = 0; mTrapPend = 0;
    repeat (3) @(posedge clk);
    #1;
    checkRegs("reset R1");
    chk("R1 trapPending after reset", trapPending, 0);
    rstN = 1;
    for (int f = 0; f < 4; f++) begin clr(); step("fill R11"); end

    clr(); for (int i = 0; i < 4; i++) put(i, 0); step("full width R3 R10");
    clr(); put(0, 1); put(1, 0); put(2, 1); put(3, 0); step("squash free R3");
    clr(); put(0, 0); put(1, 0); put(2, 1); step("width stops squash R3");
    clr(); put(0, 0); hv[1] = 1; put(2, 0); step("not ready R2");
    clr(); for (int i = 0; i < 4; i++) put(i, 0); selValid = 0; step("no thread R2");
    clr(); put(0, 2); storesPending = 1; step("nonspec blocked R5");
    clr(); put(0, 2); step("nonspec request R5");
    clr(); put(0, 0); put(1, 3); step("commit then barrier R5");
    clr(); put(0, 4); storesPending = 1; step("uncached load R6");
    clr(); put(0, 0); put(1, 4); step("commit then load R6");
    clr(); put(0, 1); hv[1] = 1; hr[1] = 1; step("unknown unexecuted R6");
    clr(); put(0, 6); put(1, 0); step("nop excluded R9");
    clr(); put(0, 0); put(1, 5); step("fault not first R7");
    clr(); put(0, 5); storesPending = 1; step("fault stores R7");
    clr(); put(0, 1); put(1, 5); step("fault after squash R7");
    clr(); put(0, 0); step("trap holds R8");
    clr(); put(0, 0); trapResume = 1; step("trap release R8");
    clr(); put(0, 0); put(1, 0); step("after release R8");

    for (int n = 0; n < 3000; n++) begin
      int nv;
      clr();
      nv = $urandom % (LOOK + 1);
      if (nv > mOcc) nv = mOcc;
      for (int i = 0; i < nv; i++) begin
        hv[i] = 1;
        hr[i] = ($urandom % 8) != 0;
        hsq[i] = ($urandom % 4) == 0;
        hex[i] = ($urandom % 4) != 0;
        hns[i] = ($urandom % 6) == 0;
        hbar[i] = ($urandom % 8) == 0;
        hld[i] = ($urandom % 3) == 0;
        hflt[i] = ($urandom % 10) == 0;
        hnop[i] = ($urandom % 5) == 0;
      end
      selValid = ($urandom % 8) != 0;
      storesPending = ($urandom % 4) == 0;
      trapResume = ($urandom % 2) == 0;
      insertCount = OCC_W'($urandom % (DEPTH - mOcc + 1));
      step("random");
    end

    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule